// File: doc/BRIEF.md
# Outgoing Call Detector

This block sits behind a telephone line interface. It receives two one-bit status inputs: a raw ring indication and a raw off-hook indication. It decides whether the handset went off hook to place a call or to answer one. Only calls placed locally raise `call_active`, so a downstream meter can bill them. Answered incoming calls keep it low for their whole length.

Both inputs first pass through two-flop synchronizers. A hold counter stretches the synchronized ring indication across the quiet gaps of the ring cadence. Its reload value, `HOLD_CYCLES`, defaults to four seconds at 100 MHz.

On the cycle the synchronized off-hook level rises, the block samples the stretched ring flag and records the call class. It keeps that class until the handset is back on hook. One-cycle pulses mark the start and the end of each outgoing call.

Top module: `outcall_detect`

## Requirements
- R1: `off_hook` equals `hook_raw` delayed by two clock cycles (two-flop synchronizer), and the raw ring input is likewise delayed by two cycles before any use.
- R2: `ring_held` is high while the synchronized ring input is high, and for exactly `HOLD_CYCLES` further cycles after it drops; a new ring pulse reloads the hold.
- R3: While `ring_held` is high and `off_hook` is low, `call_active` is low.
- R4: If `ring_held` is high in the cycle that `off_hook` first reads high, `call_active` stays low for the entire call, even after `ring_held` decays.
- R5: If `ring_held` is low in the cycle that `off_hook` first reads high, `call_active` rises on the next cycle and stays high while `off_hook` stays high.
- R6: One cycle after `off_hook` reads low, `call_active` is low and the block is idle, ready to classify the next call.
- R7: A ring pulse and an off-hook edge that reach the synchronized domain in the same cycle classify the call as incoming (`call_active` stays low).
- R8: `call_start` is a one-cycle pulse, high in the first cycle that `call_active` is high for an outgoing call, and at no other time.
- R9: `call_end` is a one-cycle pulse, high in the first cycle that `call_active` is low after an outgoing call ends on hang-up, and at no other time.
- R10: Synchronous active-high `rst` clears the synchronizers and the hold counter, and drives every output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_raw | input | 1 | Asynchronous ring indication from the line interface |
| hook_raw | input | 1 | Asynchronous off-hook indication, high when the handset is lifted |
| ring_held | output | 1 | Synchronized ring flag stretched by the hold counter |
| off_hook | output | 1 | Synchronized off-hook level |
| call_active | output | 1 | High for the duration of an outgoing call |
| call_start | output | 1 | One-cycle pulse at the start of an outgoing call |
| call_end | output | 1 | One-cycle pulse at the end of an outgoing call |

## Verification
The two functions that can collide in one cycle are the arrival of the first ring pulse and the off-hook edge, each after its own synchronizer. The bench drives both raw inputs on the same clock edge, so that the ring flag and the off-hook edge appear together. It expects the incoming class: `call_active` and `call_start` stay low for the whole call. A second collision is also covered. The handset is lifted in the very cycle after the hold counter expires, and that call must be classed as outgoing. A behavioural model judges both cases on every clock.

// File: rtl/outcall_detect.sv
module outcall_detect #(
  parameter int HOLD_CYCLES = 400_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic ring_raw,
  input  logic hook_raw,
  output logic ring_held,
  output logic off_hook,
  output logic call_active,
  output logic call_start,
  output logic call_end
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYCLES);

  logic [1:0]    ring_sync, hook_sync;
  logic          hook_q;
  logic [CW-1:0] hold_cnt;
  logic          outgoing, start_q, end_q;

  wire ring_s    = ring_sync[1];
  wire hook_s    = hook_sync[1];
  wire hook_rise = hook_s & ~hook_q;
  wire hook_fall = ~hook_s & hook_q;
  wire ring_now  = ring_s | (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_sync <= '0;
      hook_sync <= '0;
      hook_q    <= 1'b0;
    end else begin
      ring_sync <= {ring_sync[0], ring_raw};
      hook_sync <= {hook_sync[0], hook_raw};
      hook_q    <= hook_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      hold_cnt <= '0;
    else if (ring_s)
      hold_cnt <= RELOAD;
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outgoing <= 1'b0;
      start_q  <= 1'b0;
      end_q    <= 1'b0;
    end else begin
      start_q <= hook_rise & ~ring_now;
      end_q   <= hook_fall & outgoing;
      if (!hook_s)
        outgoing <= 1'b0;
      else if (hook_rise)
        outgoing <= ~ring_now;
    end
  end

  assign ring_held   = ring_now;
  assign off_hook    = hook_s;
  assign call_active = outgoing;
  assign call_start  = start_q;
  assign call_end    = end_q;
endmodule

// File: rtl/outcall_detect_chk.sv
module outcall_detect_chk (
  input logic clk,
  input logic rst,
  input logic ring_held,
  input logic off_hook,
  input logic call_active,
  input logic call_start,
  input logic call_end
);
  AST_RING_ONHOOK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ring_held && !off_hook && !$past(off_hook)) |-> !call_active); // R3
  AST_INCOMING_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (off_hook && !$past(off_hook) && ring_held) |=> !call_active); // R4
  AST_OUTGOING_KEPT: assert property (@(posedge clk) disable iff (rst)
    ($past(call_active) && $past(off_hook) && off_hook) |-> call_active); // R5
  AST_IDLE_ONHOOK: assert property (@(posedge clk) disable iff (rst)
    (!off_hook) |=> !call_active); // R6
  AST_START_EDGE: assert property (@(posedge clk) disable iff (rst)
    call_start |-> (call_active && !$past(call_active))); // R8
  AST_START_ONLY: assert property (@(posedge clk) disable iff (rst)
    (call_active && !$past(call_active)) |-> call_start); // R8
  AST_END_EDGE: assert property (@(posedge clk) disable iff (rst)
    call_end |-> (!call_active && $past(call_active))); // R9
  AST_END_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!call_active && $past(call_active)) |-> call_end); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!call_active && !call_start && !call_end && !off_hook && !ring_held)); // R10
endmodule

bind outcall_detect outcall_detect_chk u_chk (
  .clk(clk), .rst(rst), .ring_held(ring_held), .off_hook(off_hook),
  .call_active(call_active), .call_start(call_start), .call_end(call_end)
);

// File: tb/outcall_detect_tb.sv
module outcall_detect_tb;
  localparam int HOLD = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_raw = 1'b0;
  logic hook_raw = 1'b0;
  logic ring_held, off_hook, call_active, call_start, call_end;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  outcall_detect #(.HOLD_CYCLES(HOLD)) u_dut (
    .clk(clk), .rst(rst), .ring_raw(ring_raw), .hook_raw(hook_raw),
    .ring_held(ring_held), .off_hook(off_hook), .call_active(call_active),
    .call_start(call_start), .call_end(call_end)
  );

  always #5 clk = ~clk;

  bit ring_q[$];
  bit hook_q[$];
  bit m_prev_hook;
  int m_cnt;
  bit m_out, m_start, m_end;
  bit m_ring, m_hook;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ring_q = {1'b0, 1'b0};
      hook_q = {1'b0, 1'b0};
      m_prev_hook = 0; m_cnt = 0; m_out = 0; m_start = 0; m_end = 0;
    end else begin
      bit ring_old, hook_old, ringing;
      ring_old = ring_q[0];
      hook_old = hook_q[0];
      ringing  = ring_old || (m_cnt > 0);
      m_start  = hook_old && !m_prev_hook && !ringing;
      m_end    = !hook_old && m_prev_hook && m_out;
      if (!hook_old) m_out = 0;
      else if (!m_prev_hook) m_out = !ringing;
      if (ring_old) m_cnt = HOLD;
      else if (m_cnt > 0) m_cnt--;
      m_prev_hook = hook_old;
      void'(ring_q.pop_front());
      void'(hook_q.pop_front());
      ring_q.push_back(ring_raw);
      hook_q.push_back(hook_raw);
    end
    m_ring = ring_q[0];
    m_hook = hook_q[0];
  end

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(off_hook, m_hook, "R1 off_hook");
      check(ring_held, m_ring || (m_cnt > 0), "R2 ring_held");
      check(call_active, m_out, "R4/R5/R6 call_active");
      check(call_start, m_start, "R8 call_start");
      check(call_end, m_end, "R9 call_end");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    check(call_active, 1'b0, "R10 reset call_active");
    check(ring_held, 1'b0, "R10 reset ring_held");
    check(off_hook, 1'b0, "R10 reset off_hook");
    rst = 1'b0;
    step(2);

    // R5 outgoing call, R8/R9 pulses
    hook_raw = 1'b1;
    step(3);
    check(call_active, 1'b1, "R5 outgoing active");
    step(20);
    check(call_active, 1'b1, "R5 outgoing held");
    hook_raw = 1'b0;
    step(3);
    check(call_active, 1'b0, "R6 idle after hang-up");
    step(5);

    // R3/R4 incoming with cadence gaps
    for (int b = 0; b < 3; b++) begin
      ring_raw = 1'b1; step(4);
      ring_raw = 1'b0; step(10);
      check(ring_held, 1'b1, "R2 held in gap");
      check(call_active, 1'b0, "R3 ringing on hook");
    end
    hook_raw = 1'b1;
    step(HOLD + 10);
    check(ring_held, 1'b0, "R2 decayed");
    check(call_active, 1'b0, "R4 incoming stays low");
    hook_raw = 1'b0;
    step(6);

    // R7 simultaneous first ring and off-hook
    ring_raw = 1'b1; hook_raw = 1'b1;
    step(3);
    ring_raw = 1'b0;
    step(HOLD + 8);
    check(call_active, 1'b0, "R7 same-cycle is incoming");
    hook_raw = 1'b0;
    step(6);

    // off-hook right as the hold expires
    ring_raw = 1'b1; step(2); ring_raw = 1'b0;
    step(HOLD);
    hook_raw = 1'b1;
    step(HOLD + 6);
    check(call_active, 1'b1, "R5 lift after hold expired");
    hook_raw = 1'b0;
    step(6);

    // ring arriving during an outgoing call
    hook_raw = 1'b1; step(5);
    ring_raw = 1'b1; step(3); ring_raw = 1'b0; step(5);
    check(call_active, 1'b1, "R5 ring during outgoing call");
    // R10 reset mid-call
    rst = 1'b1; step(2);
    check(call_active, 1'b0, "R10 reset mid-call");
    rst = 1'b0; hook_raw = 1'b0;
    step(10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule